// File: doc/BRIEF.md
# Serial Data Shift Register for a Two-Wire Bus Engine

This block is the byte register at the heart of a two-wire serial engine. The CPU loads a byte through a small register port. The bus controller then issues one shift strobe per clock-line rising edge. On each strobe the register moves left by one place and takes in the data-line level actually present on the bus, so the byte goes out most-significant bit first. The same register receives while it transmits, and it always ends the byte holding what was really on the wire.

The data-line output is open-drain. The block asks for the line to be pulled low only while it transmits, owns the byte and its current top bit is 0. If the block releases the line to send a 1 but samples a 0, it records a lost arbitration. It then stops driving for the rest of the byte and keeps capturing bits. When the byte ends, the register already holds the winning master's address or data, ready for slave reception without a reload.

A byte-complete flag gives the register to the CPU. While the flag is set, shifting is frozen and CPU writes take effect. While the flag is clear, shifting runs and CPU writes are dropped. The CPU hands a byte to the bus by acknowledging the flag.

Top module: `smb_shift_reg`

## Requirements
- R1: After reset, cpu_rd_data is 0x00, byte_done is 1, arb_lost is 0 and sda_pull_low is 0.
- R2: A write (cpu_wr_en=1) while byte_done=1 places cpu_wr_data in the register, and cpu_rd_data shows it from the next cycle. A write while byte_done=0 is ignored.
- R3: cpu_ack=1 while byte_done=1 clears byte_done and arb_lost in the next cycle and restarts the bit count at zero. cpu_ack while byte_done=0 has no effect. A write and an ack in the same cycle both take effect.
- R4: Each shift_strobe while byte_done=0 shifts the register left by one and puts sda_in into bit 0. The first bit sampled therefore ends in bit 7.
- R5: byte_done rises in the cycle after the eighth strobe of a byte. Strobes while byte_done=1 leave the register, the flags and the output unchanged.
- R6: sda_pull_low is 1 exactly when byte_done=0, tx_mode=1, arb_lost=0 and bit 7 of the register is 0. Otherwise it is 0, meaning the line is released.
- R7: A strobe with byte_done=0, tx_mode=1, arb_lost=0, register bit 7 equal to 1 and sda_in=0 sets arb_lost from the next cycle. arb_lost stays set until the next ack.
- R8: After a byte, the register holds the sampled bus byte, which is the AND of the driven value and any other driver. This also holds after a lost arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe for the data register |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_ack | input | 1 | CPU acknowledge: clears byte_done and starts a new byte |
| cpu_rd_data | output | 8 | Current register contents |
| tx_mode | input | 1 | 1 = transmit (drive the line), 0 = receive only |
| shift_strobe | input | 1 | One-cycle pulse per clock-line rising edge |
| sda_in | input | 1 | Sampled data-line level |
| sda_pull_low | output | 1 | Open-drain request: 1 pulls the data line low |
| byte_done | output | 1 | Byte-complete flag; the CPU owns the register while it is set |
| arb_lost | output | 1 | Lost arbitration in the current byte |

## Verification
The hardest situation to reach is a lost arbitration in the middle of a byte. The block must be releasing the line for a 1 while another driver holds it low, and afterwards it must keep capturing bits with its output released. The bench models a second master whose bit is ANDed with the block's own output to form sda_in. Byte patterns are chosen so that the contention first appears at an inner bit. The final byte is then checked against the bus value, not the loaded value. Writes during a byte and strobes while the flag is set are applied between shifts, so that a dropped write or a frozen shift shows at cpu_rd_data.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int unsigned SMB_DATA_W = 8;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } reg_act_e;

endpackage

// File: rtl/smb_bit_counter.sv
module smb_bit_counter #(
    parameter int unsigned DATA_W = smb_pkg::SMB_DATA_W,
    localparam int unsigned CNT_W = $clog2(DATA_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last_bit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (inc) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_bit = (st_q.cnt == LAST);

endmodule

// File: rtl/smb_shift_core.sv
module smb_shift_core #(
    parameter int unsigned DATA_W = smb_pkg::SMB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack,
    input  logic              tx_mode,
    input  logic              strobe,
    input  logic              sda_in,
    input  logic              last_bit,
    output logic              take_bit,
    output logic              rearm,
    output logic [DATA_W-1:0] data,
    output logic              flag,
    output logic              lost,
    output logic              pull_low
);
    import smb_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              flag;
        logic              lost;
    } core_state_t;

    core_state_t st_d, st_q;
    reg_act_e    act;
    logic        released;

    // Choose the register action for this cycle.
    always_comb begin
        act = ACT_HOLD;
        if (st_q.flag) begin
            if (wr_en) begin
                act = ACT_LOAD;
            end
        end else if (strobe) begin
            act = ACT_SHIFT;
        end
    end

    assign take_bit = (act == ACT_SHIFT);
    assign rearm    = st_q.flag && ack;
    assign released = !(tx_mode && !st_q.lost && !st_q.data[DATA_W-1]);

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD:  st_d.data = wr_data;
            ACT_SHIFT: st_d.data = {st_q.data[DATA_W-2:0], sda_in};
            default:   st_d.data = st_q.data;
        endcase
        if (act == ACT_SHIFT) begin
            if (tx_mode && released && !sda_in) begin
                st_d.lost = 1'b1;
            end
            if (last_bit) begin
                st_d.flag = 1'b1;
            end
        end
        if (rearm) begin
            st_d.flag = 1'b0;
            st_d.lost = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.flag <= 1'b1;
            st_q.lost <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data     = st_q.data;
    assign flag     = st_q.flag;
    assign lost     = st_q.lost;
    assign pull_low = !st_q.flag && !released;

endmodule

// File: rtl/smb_shift_reg.sv
module smb_shift_reg #(
    parameter int unsigned DATA_W = smb_pkg::SMB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rd_data,
    input  logic              tx_mode,
    input  logic              shift_strobe,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic              byte_done,
    output logic              arb_lost
);

    logic take_bit;
    logic rearm;
    logic last_bit;

    smb_bit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rearm),
        .inc      (take_bit),
        .last_bit (last_bit)
    );

    smb_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr_en),
        .wr_data  (cpu_wr_data),
        .ack      (cpu_ack),
        .tx_mode  (tx_mode),
        .strobe   (shift_strobe),
        .sda_in   (sda_in),
        .last_bit (last_bit),
        .take_bit (take_bit),
        .rearm    (rearm),
        .data     (cpu_rd_data),
        .flag     (byte_done),
        .lost     (arb_lost),
        .pull_low (sda_pull_low)
    );

endmodule

// File: rtl/smb_shift_reg_chk.sv
module smb_shift_reg_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_en,
    input logic              cpu_ack,
    input logic [DATA_W-1:0] cpu_rd_data,
    input logic              tx_mode,
    input logic              shift_strobe,
    input logic              sda_in,
    input logic              sda_pull_low,
    input logic              byte_done,
    input logic              arb_lost
);

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !cpu_wr_en |=> $stable(cpu_rd_data));

    p_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done && !shift_strobe |=> $stable(cpu_rd_data));

    p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done && shift_strobe |=>
            cpu_rd_data == {$past(cpu_rd_data[DATA_W-2:0]), $past(sda_in)});

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done || arb_lost || !tx_mode) |-> !sda_pull_low);

    p_arb_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done && tx_mode && !arb_lost && shift_strobe && !sda_pull_low && !sda_in
            |=> arb_lost);

    p_arb_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost && !cpu_ack |=> arb_lost);

    p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && cpu_ack |=> !byte_done && !arb_lost);

endmodule

bind smb_shift_reg smb_shift_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_en    (cpu_wr_en),
    .cpu_ack      (cpu_ack),
    .cpu_rd_data  (cpu_rd_data),
    .tx_mode      (tx_mode),
    .shift_strobe (shift_strobe),
    .sda_in       (sda_in),
    .sda_pull_low (sda_pull_low),
    .byte_done    (byte_done),
    .arb_lost     (arb_lost)
);

// File: tb/smb_shift_reg_tb.sv
`timescale 1ns/1ps
module smb_shift_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = 8'h00;
    logic       cpu_ack = 1'b0;
    logic [7:0] cpu_rd_data;
    logic       tx_mode = 1'b0;
    logic       shift_strobe = 1'b0;
    logic       sda_in = 1'b1;
    logic       sda_pull_low;
    logic       byte_done;
    logic       arb_lost;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model
    int m_data = 0;
    int m_cnt = 0;
    bit m_flag = 1;
    bit m_lost = 0;

    always #5 clk = ~clk;

    smb_shift_reg u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_ack(cpu_ack), .cpu_rd_data(cpu_rd_data), .tx_mode(tx_mode),
        .shift_strobe(shift_strobe), .sda_in(sda_in), .sda_pull_low(sda_pull_low),
        .byte_done(byte_done), .arb_lost(arb_lost)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_pull();
        return !m_flag && tx_mode && !m_lost && ((m_data & 8'h80) == 0);
    endfunction

    task automatic compare_all();
        chk("R4 data", int'(cpu_rd_data), m_data);
        chk("R5 byte_done", int'(byte_done), int'(m_flag));
        chk("R7 arb_lost", int'(arb_lost), int'(m_lost));
        chk("R6 sda_pull_low", int'(sda_pull_low), int'(m_pull()));
    endtask

    // One clock: inputs already set at negedge; update model at posedge.
    task automatic step();
        bit strobe_v, sda_v, wr_v, ack_v, tx_v, rel_v;
        int wd_v;
        strobe_v = shift_strobe; sda_v = sda_in; wr_v = cpu_wr_en;
        ack_v = cpu_ack; tx_v = tx_mode; wd_v = int'(cpu_wr_data);
        rel_v = !m_pull();
        @(posedge clk);
        if (m_flag) begin
            if (wr_v) m_data = wd_v;
            if (ack_v) begin m_flag = 0; m_lost = 0; m_cnt = 0; end
        end else if (strobe_v) begin
            if (tx_v && rel_v && !sda_v) m_lost = 1;
            m_data = ((m_data << 1) | int'(sda_v)) & 8'hFF;
            m_cnt++;
            if (m_cnt == 8) begin m_flag = 1; m_cnt = 0; end
        end
        @(negedge clk);
        cpu_wr_en = 0; cpu_ack = 0; shift_strobe = 0;
        compare_all();
    endtask

    task automatic cpu_write(input logic [7:0] v);
        cpu_wr_en = 1; cpu_wr_data = v; step();
    endtask

    task automatic cpu_do_ack();
        cpu_ack = 1; step();
    endtask

    // One bus bit: other master drives other_bit, bus is wired-AND.
    task automatic bus_bit(input bit other_bit);
        sda_in = other_bit & !sda_pull_low;
        shift_strobe = 1;
        step();
        step();
    endtask

    task automatic bus_byte(input logic [7:0] other);
        for (int i = 7; i >= 0; i--) bus_bit(other[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset data", int'(cpu_rd_data), 0);
        chk("R1 reset byte_done", int'(byte_done), 1);
        chk("R1 reset arb_lost", int'(arb_lost), 0);
        chk("R1 reset pull", int'(sda_pull_low), 0);

        // R2 write while flag set
        cpu_write(8'hA5);
        chk("R2 write visible", int'(cpu_rd_data), 8'hA5);
        // R5 strobe while flag set is ignored
        sda_in = 0; shift_strobe = 1; step();
        chk("R5 frozen strobe", int'(cpu_rd_data), 8'hA5);

        // transmit A5 with no contention
        tx_mode = 1;
        cpu_do_ack();
        chk("R3 ack clears flag", int'(byte_done), 0);
        // R2 write while clear ignored
        cpu_write(8'h11);
        chk("R2 write ignored", int'(cpu_rd_data), 8'hA5);
        // R3 ack while clear has no effect
        cpu_do_ack();
        chk("R3 ack ignored", int'(byte_done), 0);
        bus_byte(8'hFF);
        chk("R8 tx byte on bus", int'(cpu_rd_data), 8'hA5);
        chk("R5 done after 8", int'(byte_done), 1);

        // receive mode: other master sends 3C
        tx_mode = 0;
        cpu_do_ack();
        bus_byte(8'h3C);
        chk("R8 rx byte", int'(cpu_rd_data), 8'h3C);
        chk("R4 first bit in msb", int'(cpu_rd_data[7]), 0);

        // arbitration loss: write+ack same cycle, send F0 vs other C3
        tx_mode = 1;
        cpu_wr_en = 1; cpu_wr_data = 8'hF0; cpu_ack = 1; step();
        chk("R3 write and ack", int'(cpu_rd_data), 8'hF0);
        bus_byte(8'hC3);
        chk("R7 lost flagged", int'(arb_lost), 1);
        chk("R8 bus byte after loss", int'(cpu_rd_data), 8'hC3);
        cpu_do_ack();
        chk("R3 ack clears lost", int'(arb_lost), 0);

        // second arbitration case: loss at the last bit
        bus_byte(8'hC2);
        chk("R7 lost late", int'(arb_lost), 1);
        chk("R8 bus byte late loss", int'(cpu_rd_data), 8'hC2);

        // zero byte drives low all bits
        cpu_write(8'h00);
        cpu_do_ack();
        chk("R6 pull low on zero", int'(sda_pull_low), 1);
        bus_byte(8'hFF);
        chk("R8 zero byte", int'(cpu_rd_data), 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule